// File: doc/BRIEF.md
# Dual-Channel Result Output Port

This block holds two conversion results, one per channel, and presents them to a host through one of two ports. A static port-select input chooses the port. In parallel mode the block drives a full-width data bus with one of the two results. A channel-select input picks the result, and a byte-swap input can exchange the two bytes. In serial mode the block releases the whole bus. Some bus pins then become configuration inputs, and both results leave as one 32-bit frame on a single data line, framed by a SYNC signal.

The serial clock comes from one of two sources. In master mode the block generates it from the system clock through a selectable divider. In slave mode the host supplies it. A one-cycle load strobe copies both channel inputs into holding registers, and in serial mode this starts a frame. If a load arrives while a frame is running, it is kept and its frame starts when the current one ends. The shared bus is modelled as separate drive-data and output-enable vectors, with a separate input vector for the pins read back in serial mode.

Top module: `dual_result_port`

## Requirements
- R1: After reset, with parallel mode selected, all 16 enables of `pin_oe_o` are high, `pin_out_o` is zero, `sclk_out_o` is low and `sync_o` is low.
- R2: With `ser_sel_i` low, every bus pin is driven (`pin_oe_o` all ones). With `ser_sel_i` high, every bus pin is released (`pin_oe_o` all zeros), which includes pins 0 and 1.
- R3: In parallel mode, `chan_a_i` high puts the channel A result on the bus, and low puts the channel B result on the bus.
- R4: In parallel mode, `swap_i` low gives the result's low byte on pins 7..0 and its high byte on pins 15..8. `swap_i` high exchanges the two bytes.
- R5: A one-cycle `load_i` pulse captures both `res_a_i` and `res_b_i`. If no load occurs, changes on those inputs do not reach the outputs.
- R6: A serial frame is 32 bits, sent MSB first. If `chan_a_i` is high, the channel A word comes first and the channel B word follows. If it is low, channel B comes first. `sdout_o` is low outside a frame.
- R7: SYNC is active for the whole frame and inactive between frames. In master mode, pin 5 = 0 makes SYNC active high and pin 5 = 1 makes it active low. In slave mode SYNC is always active high.
- R8: Master mode is selected in serial mode with pin 4 = 0. The block then drives the serial clock (`sclk_oe_o` high). The clock stays low outside a frame, its period during a frame is 2^(d+1) system clocks, and `sdout_o` changes only as the serial clock falls.
- R9: The divider code d is pins 3..2 (pin 2 is the LSB). It is used only when `rdc_i` is high in master mode. When `rdc_i` is low, d is taken as 0 (divide by 2), whatever those pins hold.
- R10: Slave mode is selected in serial mode with pin 4 = 1. `sclk_oe_o` is then low and `sclk_out_o` is low. The data advances one bit on each falling edge of `sclk_in_i`, and each bit can be sampled on the rising edge.
- R11: A load that arrives during a serial frame does not disturb that frame. After the frame ends, a new frame carries the data from that later load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | One-cycle capture strobe for both results |
| res_a_i | input | 16 | Channel A conversion result |
| res_b_i | input | 16 | Channel B conversion result |
| ser_sel_i | input | 1 | Port select: 0 parallel, 1 serial |
| chan_a_i | input | 1 | Parallel: 1 selects A, 0 selects B. Serial: 1 sends A first |
| swap_i | input | 1 | Parallel byte exchange |
| rdc_i | input | 1 | Read-after-convert select; enables the divider code |
| pin_in_i | input | 16 | Bus pins as read back (serial configuration) |
| pin_out_o | output | 16 | Bus pin drive data |
| pin_oe_o | output | 16 | Bus pin output enables |
| sclk_in_i | input | 1 | Host serial clock (slave mode) |
| sclk_out_o | output | 1 | Generated serial clock (master mode) |
| sclk_oe_o | output | 1 | Serial clock drive enable |
| sdout_o | output | 1 | Serial data |
| sync_o | output | 1 | Frame sync |

## Verification
Some properties are checked on every cycle: the bus enables follow the port select, the parallel bus holds steady when neither a load nor a select input changes, the generated clock rests low and stays undriven in slave mode, and the serial data stays steady while the generated clock is high. The bench scenarios cover the rest, because each of these needs a whole frame to show. They check the bit order and channel order of complete frames, the measured clock period for every divider code with and without read-after-convert, SYNC polarity across a frame, slave-clocked frames, and a load made mid-frame that comes out in the following frame.

// File: rtl/drp_pkg.sv
package drp_pkg;
  // bus pin roles while the serial port is selected
  localparam int unsigned PIN_DIV_LSB = 2;
  localparam int unsigned DIV_W       = 2;
  localparam int unsigned PIN_EXT     = 4;
  localparam int unsigned PIN_INV     = 5;

  typedef struct packed {
    logic             slave;
    logic             inv_sync;
    logic [DIV_W-1:0] div;
  } ser_cfg_t;
endpackage

// File: rtl/drp_hold.sv
module drp_hold #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              ser_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] hold_a_o,
  output logic [WORD_W-1:0] hold_b_o,
  output logic              start_o
);
  logic [WORD_W-1:0] hold_a_q, hold_a_d, hold_b_q, hold_b_d;
  logic [WORD_W-1:0] pend_a_q, pend_a_d, pend_b_q, pend_b_d;
  logic              pend_q, pend_d, start_q, start_d;
  logic              blocked, accept, drain;

  always_comb begin
    blocked  = ser_i && (busy_i || start_q);
    accept   = load_i && !blocked;
    drain    = pend_q && !blocked && !load_i;
    hold_a_d = hold_a_q;
    hold_b_d = hold_b_q;
    pend_a_d = pend_a_q;
    pend_b_d = pend_b_q;
    pend_d   = pend_q;
    start_d  = 1'b0;
    if (accept) begin
      hold_a_d = a_i;
      hold_b_d = b_i;
      pend_d   = 1'b0;
      start_d  = ser_i;
    end else if (load_i) begin
      pend_a_d = a_i;
      pend_b_d = b_i;
      pend_d   = 1'b1;
    end else if (drain) begin
      hold_a_d = pend_a_q;
      hold_b_d = pend_b_q;
      pend_d   = 1'b0;
      start_d  = ser_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a_q <= '0;
      hold_b_q <= '0;
      pend_a_q <= '0;
      pend_b_q <= '0;
      pend_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      hold_a_q <= hold_a_d;
      hold_b_q <= hold_b_d;
      pend_a_q <= pend_a_d;
      pend_b_q <= pend_b_d;
      pend_q   <= pend_d;
      start_q  <= start_d;
    end
  end

  assign hold_a_o = hold_a_q;
  assign hold_b_o = hold_b_q;
  assign start_o  = start_q;
endmodule

// File: rtl/drp_sclk_gen.sv
module drp_sclk_gen #(
  parameter int unsigned DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o
);
  localparam int unsigned CNT_W = 2 ** DIV_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             sclk_q, sclk_d, term;

  always_comb begin
    half_m1 = (CNT_W'(1) << div_i) - CNT_W'(1);
    term    = (cnt_q == half_m1);
    cnt_d   = cnt_q;
    sclk_d  = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (term) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = run_i && term && sclk_q;
endmodule

// File: rtl/drp_shifter.sv
module drp_shifter #(
  parameter int unsigned FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               shift_i,
  output logic               active_o,
  output logic               sdo_o
);
  localparam int unsigned CW = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic               act_q, act_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (start_i) begin
      sr_d  = word_i;
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q && shift_i) begin
      sr_d = {sr_q[FRAME_W-2:0], 1'b0};
      if (cnt_q == CW'(FRAME_W - 1)) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;
  assign sdo_o    = act_q & sr_q[FRAME_W-1];
endmodule

// File: rtl/dual_result_port.sv
module dual_result_port
  import drp_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] res_a_i,
  input  logic [WORD_W-1:0] res_b_i,
  input  logic              ser_sel_i,
  input  logic              chan_a_i,
  input  logic              swap_i,
  input  logic              rdc_i,
  input  logic [WORD_W-1:0] pin_in_i,
  output logic [WORD_W-1:0] pin_out_o,
  output logic [WORD_W-1:0] pin_oe_o,
  input  logic              sclk_in_i,
  output logic              sclk_out_o,
  output logic              sclk_oe_o,
  output logic              sdout_o,
  output logic              sync_o
);
  localparam int unsigned FRAME_W = 2 * WORD_W;
  localparam int unsigned LANE_W  = WORD_W / 2;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  // serial configuration read from the shared pins
  ser_cfg_t         cfg;
  logic             master;
  logic [DIV_W-1:0] div_eff;
  always_comb begin
    cfg.slave    = pin_in_i[PIN_EXT];
    cfg.inv_sync = pin_in_i[PIN_INV];
    cfg.div      = pin_in_i[PIN_DIV_LSB +: DIV_W];
    master       = ser_sel_i && !cfg.slave;
    div_eff      = (master && rdc_i) ? cfg.div : '0;
  end

  // host clock synchroniser and falling-edge detect
  logic [2:0] hsclk_q, hsclk_d;
  logic       host_fall;
  always_comb hsclk_d = {hsclk_q[1:0], sclk_in_i};
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) hsclk_q <= '0;
    else            hsclk_q <= hsclk_d;
  end
  assign host_fall = hsclk_q[2] & ~hsclk_q[1];

  logic [WORD_W-1:0]  hold_a, hold_b;
  logic               start, active, sdo, gen_sclk, gen_fall, shift;
  logic [FRAME_W-1:0] frame_word;

  drp_hold #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_i   (load_i),
    .ser_i    (ser_sel_i),
    .busy_i   (active),
    .a_i      (res_a_i),
    .b_i      (res_b_i),
    .hold_a_o (hold_a),
    .hold_b_o (hold_b),
    .start_o  (start)
  );

  drp_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .run_i  (active && master),
    .div_i  (div_eff),
    .sclk_o (gen_sclk),
    .fall_o (gen_fall)
  );

  always_comb begin
    frame_word = chan_a_i ? {hold_a, hold_b} : {hold_b, hold_a};
    shift      = master ? gen_fall : (ser_sel_i && cfg.slave && host_fall);
  end

  drp_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start),
    .word_i   (frame_word),
    .shift_i  (shift),
    .active_o (active),
    .sdo_o    (sdo)
  );

  // parallel lanes, optionally exchanged
  logic [WORD_W-1:0] par_sel, par_data;
  assign par_sel = chan_a_i ? hold_a : hold_b;
  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign par_data[g*LANE_W +: LANE_W] =
      swap_i ? par_sel[(1-g)*LANE_W +: LANE_W] : par_sel[g*LANE_W +: LANE_W];
  end

  assign pin_oe_o   = ser_sel_i ? '0 : '1;
  assign pin_out_o  = ser_sel_i ? '0 : par_data;
  assign sclk_out_o = gen_sclk & master;
  assign sclk_oe_o  = master;
  assign sdout_o    = sdo;
  assign sync_o     = active ^ (master & cfg.inv_sync);
endmodule

// File: rtl/dual_result_port_chk.sv
module dual_result_port_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              ser_sel_i,
  input logic              chan_a_i,
  input logic              swap_i,
  input logic [WORD_W-1:0] pin_in_i,
  input logic [WORD_W-1:0] pin_out_o,
  input logic [WORD_W-1:0] pin_oe_o,
  input logic              sclk_out_o,
  input logic              sclk_oe_o,
  input logic              sdout_o,
  input logic              sync_o
);
  logic ext, inv, mst, sync_act;
  assign ext      = pin_in_i[4];
  assign inv      = pin_in_i[5];
  assign mst      = ser_sel_i && !ext;
  assign sync_act = sync_o ^ (inv && mst);

  p_par_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_sel_i |-> (&pin_oe_o));
  p_ser_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sel_i |-> (pin_oe_o == '0));
  p_par_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel_i && $past(!ser_sel_i) && !$past(load_i) &&
     $stable(chan_a_i) && $stable(swap_i)) |-> $stable(pin_out_o));
  p_sdo_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel_i && !sync_act) |-> !sdout_o);
  p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && !sync_act) |-> !sclk_out_o);
  p_sdo_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mst && $past(mst) && $stable(pin_in_i) && sclk_out_o && $past(sclk_out_o))
      |-> $stable(sdout_o));
  p_slave_clk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel_i && ext) |-> (!sclk_oe_o && !sclk_out_o));
endmodule

bind dual_result_port dual_result_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .ser_sel_i  (ser_sel_i),
  .chan_a_i   (chan_a_i),
  .swap_i     (swap_i),
  .pin_in_i   (pin_in_i),
  .pin_out_o  (pin_out_o),
  .pin_oe_o   (pin_oe_o),
  .sclk_out_o (sclk_out_o),
  .sclk_oe_o  (sclk_oe_o),
  .sdout_o    (sdout_o),
  .sync_o     (sync_o)
);

// File: tb/dual_result_port_tb.sv
module dual_result_port_tb;
  logic        clk = 1'b0;
  logic        rst_n, load_i, ser_sel_i, chan_a_i, swap_i, rdc_i, sclk_in_i;
  logic [15:0] res_a_i, res_b_i, pin_in_i, pin_out_o, pin_oe_o;
  logic        sclk_out_o, sclk_oe_o, sdout_o, sync_o;
  int          nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  dual_result_port u_dut (.*);

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_load(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    res_a_i = a; res_b_i = b; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic set_cfg(input logic ext, input logic inv, input logic [1:0] div);
    pin_in_i = {10'd0, inv, ext, div, 2'b00};
  endtask

  task automatic cap_master(input logic [31:0] exp, input int per, input logic inv, input string tag);
    logic        al, prev, bad_sync, bad_per;
    logic [31:0] bits;
    int          nr, cyc, last, w;
    al = !inv; w = 0;
    while (sync_o !== al && w < 100) begin @(negedge clk); w++; end
    bits = '0; nr = 0; cyc = 0; last = 0; prev = sclk_out_o; bad_sync = 0; bad_per = 0;
    while (nr < 32 && cyc < 2000) begin
      @(negedge clk); cyc++;
      if (sync_o !== al) bad_sync = 1;
      if (sclk_out_o && !prev) begin
        bits = {bits[30:0], sdout_o};
        if (nr > 0 && (cyc - last) != per) bad_per = 1;
        last = cyc; nr++;
      end
      prev = sclk_out_o;
    end
    chk(bits == exp, {tag, " R6 frame bits"}, bits, exp);
    chk(!bad_per, {tag, " R8 R9 sclk period"}, per, per);
    chk(!bad_sync, {tag, " R7 sync held"}, bad_sync, 0);
    chk(sclk_oe_o == 1'b1, {tag, " R8 sclk driven"}, sclk_oe_o, 1);
    w = 0;
    while (sync_o === al && w < 40) begin @(negedge clk); w++; end
    chk(sync_o === !al, {tag, " R7 sync released"}, sync_o, !al);
  endtask

  task automatic cap_slave(input logic [31:0] exp, input string tag);
    logic [31:0] bits;
    int          w;
    w = 0;
    while (sync_o !== 1'b1 && w < 100) begin @(negedge clk); w++; end
    bits = '0;
    for (int i = 0; i < 32; i++) begin
      repeat (8) @(negedge clk);
      bits = {bits[30:0], sdout_o};
      sclk_in_i = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in_i = 1'b0;
    end
    chk(bits == exp, {tag, " R10 R6 slave bits"}, bits, exp);
    chk(sclk_oe_o == 1'b0, {tag, " R10 sclk undriven"}, sclk_oe_o, 0);
    w = 0;
    while (sync_o === 1'b1 && w < 20) begin @(negedge clk); w++; end
    chk(sync_o === 1'b0, {tag, " R7 slave sync ends"}, sync_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [15:0] a, b, sel, exp;
    rst_n = 0; load_i = 0; ser_sel_i = 0; chan_a_i = 0; swap_i = 0; rdc_i = 0;
    sclk_in_i = 0; res_a_i = 0; res_b_i = 0; pin_in_i = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(pin_oe_o == 16'hFFFF, "R1 reset enables", pin_oe_o, 16'hFFFF);
    chk(pin_out_o == 16'h0, "R1 reset data", pin_out_o, 0);
    chk(!sclk_out_o && !sync_o, "R1 reset serial idle", {sclk_out_o, sync_o}, 0);

    // parallel sweep: R3 channel, R4 byte order, R2 drive
    for (int k = 0; k < 6; k++) begin
      a = 16'(16'h1357 * (k + 1)) ^ 16'hA5C3;
      b = 16'(16'h2468 * (k + 3)) ^ 16'h0FF0;
      pulse_load(a, b);
      for (int c = 0; c < 2; c++) begin
        for (int s = 0; s < 2; s++) begin
          chan_a_i = c[0]; swap_i = s[0];
          @(negedge clk);
          sel = c[0] ? a : b;
          exp = s[0] ? {sel[7:0], sel[15:8]} : sel;
          chk(pin_out_o == exp, $sformatf("R3 R4 par k%0d c%0d s%0d", k, c, s), pin_out_o, exp);
          chk(pin_oe_o == 16'hFFFF, "R2 par drive", pin_oe_o, 16'hFFFF);
        end
      end
    end
    // R5: inputs change without a load
    chan_a_i = 1; swap_i = 0;
    @(negedge clk);
    exp = pin_out_o;
    res_a_i = ~res_a_i; res_b_i = ~res_b_i;
    repeat (3) @(negedge clk);
    chk(pin_out_o == exp, "R5 no load no change", pin_out_o, exp);

    // serial: R2 release
    ser_sel_i = 1; set_cfg(0, 0, 0);
    @(negedge clk);
    chk(pin_oe_o == 16'h0000, "R2 serial release", pin_oe_o, 0);
    chk(pin_oe_o[1:0] == 2'b00, "R2 pins 0 1 hi-z", pin_oe_o[1:0], 0);

    // master sweep: R6 R7 R8 R9
    for (int d = 0; d < 4; d++) begin
      for (int r = 0; r < 2; r++) begin
        for (int v = 0; v < 2; v++) begin
          a = 16'(16'h8421 + d * 16'h1111 + r * 16'h0707);
          b = 16'(16'h7BDE - d * 16'h0303 + v * 16'h5000);
          chan_a_i = (d + r + v) % 2 == 0;
          rdc_i = r[0];
          set_cfg(1'b0, v[0], d[1:0]);
          @(negedge clk);
          pulse_load(a, b);
          cap_master(chan_a_i ? {a, b} : {b, a}, r[0] ? (2 << d) : 2, v[0],
                     $sformatf("master d%0d r%0d v%0d", d, r, v));
        end
      end
    end

    // slave: R10, inversion pin ignored (R7)
    for (int c = 0; c < 2; c++) begin
      a = 16'hC0DE ^ 16'(c * 16'h0F0F);
      b = 16'h3AB5 ^ 16'(c * 16'h1248);
      chan_a_i = c[0];
      set_cfg(1'b1, 1'b1, 2'b11);
      @(negedge clk);
      pulse_load(a, b);
      cap_slave(c[0] ? {a, b} : {b, a}, $sformatf("slave c%0d", c));
    end

    // R11: load during a frame
    chan_a_i = 1; rdc_i = 1; set_cfg(1'b0, 1'b0, 2'b01);
    @(negedge clk);
    pulse_load(16'h1111, 16'h2222);
    fork
      cap_master({16'h1111, 16'h2222}, 4, 1'b0, "R11 first frame");
      begin repeat (30) @(negedge clk); pulse_load(16'hABCD, 16'h9876); end
    join
    cap_master({16'hABCD, 16'h9876}, 4, 1'b0, "R11 held frame");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule